// File: doc/BRIEF.md
# Receive Symbol Framer with Delimiter Decode

This block sits behind symbol alignment in a physical-layer receive path. Once per symbol time it takes one symbol, marked by a valid strobe. It turns the symbol stream into nibble-wide receive signals for the MAC: a data-valid flag, an error flag and a four-bit data nibble. It also provides a line-activity flag that covers every non-silent symbol of a burst.

A frame opens when a start-of-stream delimiter reaches the decode stage. It closes on an end-of-stream delimiter, which the transmitter always follows with a confirmation symbol. In the default mode, decoding works on the symbol that arrived three strobes before the newest one. Data-valid therefore rises three symbols after the start delimiter enters the block. It falls three symbols after the end delimiter enters, which is one strobe after line activity has already ended. A low-latency mode pin makes the decoder work on the current symbol. In that mode the first three symbols of every burst are thrown away, so the MAC must accept a shortened preamble.

All outputs are registered and change only on a strobe edge. Between strobes they hold their values.

Top module: `pcs_rx_framer`

## Requirements
- R1: While reset is asserted, `rx_dv`, `rx_er`, `rxd` and `line_act` are all 0.
- R2: Symbol codes on `sym_kind` are: 0 silence, 1 sync, 2 start delimiter, 3 data, 4 end delimiter, 5 end-ok, 6 end-error, 7 beacon; codes 8 to 15 are invalid. After a strobe with a non-zero code, `line_act` is 1. After a strobe with code 0, `line_act` is 0.
- R3: In default mode (`low_lat`=0), `rx_dv` rises on the third strobe after the strobe that carried a start delimiter. This happens only when no frame is open.
- R4: While a frame is open, each data symbol appears on `rxd` with the same three-strobe delay. The start delimiter itself shows as `rxd`=4'h5.
- R5: `rx_dv` falls when the end delimiter reaches decode: three strobes after it enters in default mode, or on the same strobe in low-latency mode.
- R6: An end delimiter followed by end-ok closes the frame without raising `rx_er`.
- R7: An end delimiter followed by any symbol other than end-ok raises `rx_er` for exactly one strobe, with `rx_dv` low.
- R8: Inside an open frame, a decoded symbol other than data or end delimiter raises `rx_er` for one strobe with `rxd`=0. For silence the frame also closes (`rx_dv` falls). For any other code `rx_dv` stays high.
- R9: In low-latency mode (`low_lat`=1), the symbol on the current strobe is decoded, so `rx_dv` rises on the same strobe that carries the start delimiter.
- R10: In low-latency mode, the first three non-silent symbols of a burst are discarded. A start delimiter among them opens no frame.
- R11: On a cycle where `sym_vld` is 0, none of the outputs changes.
- R12: Sync, beacon and silence symbols decoded while no frame is open leave `rx_dv` and `rx_er` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sym_vld | input | 1 | One-cycle strobe marking a new symbol |
| sym_kind | input | 4 | Symbol code (see R2) |
| sym_nib | input | 4 | Data nibble carried by a data symbol |
| low_lat | input | 1 | 1 selects decode of the current symbol with burst-start discard |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error pulse |
| rxd | output | 4 | Receive data nibble |
| line_act | output | 1 | Line activity across the whole burst |

## Verification
Some rules are checked by the bound checker on every cycle: outputs hold between strobes, the activity flag follows the silence code of the previous strobe, and every rising or falling edge of `rx_dv` lines up with the right delimiter at the decode point of the active mode. The bench scenarios are needed for the rest: the exact three-strobe assert and deassert latencies measured against the strobe index, the mapping of nibbles onto `rxd`, the one-strobe error pulses after a bad terminator or a stray code, and the discard window at the start of a low-latency burst.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;
  localparam int KIND_W = 4;
  localparam int NIB_W  = 4;

  typedef enum logic [KIND_W-1:0] {
    SYM_SILENCE = 4'd0,
    SYM_SYNC    = 4'd1,
    SYM_SSD     = 4'd2,
    SYM_DATA    = 4'd3,
    SYM_ESD     = 4'd4,
    SYM_ESDOK   = 4'd5,
    SYM_ESDERR  = 4'd6,
    SYM_BEACON  = 4'd7
  } sym_kind_e;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_OPEN = 2'd1,
    FR_TAIL = 2'd2
  } frame_st_e;

  localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
endpackage

// File: rtl/rx_sym_pipe.sv
module rx_sym_pipe #(
  parameter int DEPTH = 3,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] tap
);
  generate
    if (DEPTH == 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   stg_q <= '0;
        else if (adv) stg_q <= din;
      end
      assign tap = stg_q;
    end else begin : g_chain
      logic [DEPTH-1:0][W-1:0] stg_q;
      logic [DEPTH-1:0][W-1:0] stg_d;
      always_comb begin
        stg_d = stg_q;
        if (adv) begin
          stg_d[0] = din;
          for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
      end
      assign tap = stg_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/rx_act_track.sv
module rx_act_track #(
  parameter int SKIP_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic is_silence,
  input  logic low_lat,
  output logic line_act,
  output logic discard
);
  localparam int CW = $clog2(SKIP_N + 1);
  localparam logic [CW-1:0] SKIP_LIM = CW'(SKIP_N);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          in_window;

  // position of the current symbol inside its burst, counted from zero
  assign in_window = !act_q || (cnt_q < SKIP_LIM);
  assign discard   = low_lat && !is_silence && in_window;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (adv) begin
      if (is_silence) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        act_d = 1'b1;
        if (!act_q)               cnt_d = CW'(1);
        else if (cnt_q < SKIP_LIM) cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign line_act = act_q;
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import pcs_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [KIND_W-1:0] kind,
  input  logic [NIB_W-1:0]  nib,
  output logic              rx_dv,
  output logic              rx_er,
  output logic [NIB_W-1:0]  rxd
);
  frame_st_e        st_q, st_d;
  logic             dv_q, dv_d;
  logic             er_q, er_d;
  logic [NIB_W-1:0] rxd_q, rxd_d;

  always_comb begin
    st_d  = st_q;
    dv_d  = dv_q;
    er_d  = er_q;
    rxd_d = rxd_q;
    if (step) begin
      er_d  = 1'b0;
      rxd_d = '0;
      unique case (st_q)
        FR_IDLE: begin
          if (kind == SYM_SSD) begin
            st_d  = FR_OPEN;
            dv_d  = 1'b1;
            rxd_d = PRE_NIB;
          end else begin
            dv_d = 1'b0;
          end
        end
        FR_OPEN: begin
          if (kind == SYM_DATA) begin
            rxd_d = nib;
          end else if (kind == SYM_ESD) begin
            st_d = FR_TAIL;
            dv_d = 1'b0;
          end else if (kind == SYM_SILENCE) begin
            st_d = FR_IDLE;
            dv_d = 1'b0;
            er_d = 1'b1;
          end else begin
            er_d = 1'b1;
          end
        end
        FR_TAIL: begin
          st_d = FR_IDLE;
          dv_d = 1'b0;
          if (kind != SYM_ESDOK) er_d = 1'b1;
        end
        default: begin
          st_d = FR_IDLE;
          dv_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_IDLE;
      dv_q  <= 1'b0;
      er_q  <= 1'b0;
      rxd_q <= '0;
    end else begin
      st_q  <= st_d;
      dv_q  <= dv_d;
      er_q  <= er_d;
      rxd_q <= rxd_d;
    end
  end

  assign rx_dv = dv_q;
  assign rx_er = er_q;
  assign rxd   = rxd_q;
endmodule

// File: rtl/pcs_rx_framer.sv
module pcs_rx_framer
  import pcs_rx_pkg::*;
#(
  parameter int DEC_DELAY = 3,
  parameter int SKIP_N    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_vld,
  input  logic [KIND_W-1:0] sym_kind,
  input  logic [NIB_W-1:0]  sym_nib,
  input  logic              low_lat,
  output logic              rx_dv,
  output logic              rx_er,
  output logic [NIB_W-1:0]  rxd,
  output logic              line_act
);
  localparam int SYM_W = KIND_W + NIB_W;

  logic [SYM_W-1:0]  tap_sym;
  logic [KIND_W-1:0] dec_kind;
  logic [NIB_W-1:0]  dec_nib;
  logic              discard;

  rx_sym_pipe #(.DEPTH(DEC_DELAY), .W(SYM_W)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (sym_vld),
    .din   ({sym_kind, sym_nib}),
    .tap   (tap_sym)
  );

  rx_act_track #(.SKIP_N(SKIP_N)) u_act (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (sym_vld),
    .is_silence (sym_kind == SYM_SILENCE),
    .low_lat    (low_lat),
    .line_act   (line_act),
    .discard    (discard)
  );

  // decode point: delayed copy by default, live symbol in low-latency mode
  always_comb begin
    if (low_lat) begin
      dec_kind = sym_kind;
      dec_nib  = sym_nib;
    end else begin
      dec_kind = tap_sym[SYM_W-1:NIB_W];
      dec_nib  = tap_sym[NIB_W-1:0];
    end
    if (discard) begin
      dec_kind = SYM_SILENCE;
      dec_nib  = '0;
    end
  end

  rx_frame_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (sym_vld),
    .kind  (dec_kind),
    .nib   (dec_nib),
    .rx_dv (rx_dv),
    .rx_er (rx_er),
    .rxd   (rxd)
  );
endmodule

// File: rtl/pcs_rx_framer_chk.sv
module pcs_rx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_vld,
  input logic [3:0] sym_kind,
  input logic       low_lat,
  input logic       rx_dv,
  input logic       rx_er,
  input logic [3:0] rxd,
  input logic       line_act
);
  logic [3:0] h1, h2, h3, h4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 <= '0; h2 <= '0; h3 <= '0; h4 <= '0;
    end else if (sym_vld) begin
      h1 <= sym_kind; h2 <= h1; h3 <= h2; h4 <= h3;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> $stable({rx_dv, rx_er, rxd, line_act}));

  assert_act_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && sym_kind == 4'd0) |=> !line_act);

  assert_act_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && sym_kind != 4'd0) |=> line_act);

  assert_dv_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (low_lat ? (h1 == 4'd2) : (h4 == 4'd2)));

  assert_dv_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_dv) |-> (low_lat ? (h1 == 4'd4 || (h1 == 4'd0 && rx_er))
                              : (h4 == 4'd4 || (h4 == 4'd0 && rx_er))));

  assert_pre_nib_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (rxd == 4'h5 && !rx_er));
endmodule

bind pcs_rx_framer pcs_rx_framer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sym_vld  (sym_vld),
  .sym_kind (sym_kind),
  .low_lat  (low_lat),
  .rx_dv    (rx_dv),
  .rx_er    (rx_er),
  .rxd      (rxd),
  .line_act (line_act)
);

// File: tb/tb_pcs_rx_framer.sv
module tb_pcs_rx_framer;
  logic       clk;
  logic       rst_n;
  logic       sym_vld;
  logic [3:0] sym_kind;
  logic [3:0] sym_nib;
  logic       low_lat;
  logic       rx_dv, rx_er, line_act;
  logic [3:0] rxd;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  pcs_rx_framer dut (
    .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym_kind(sym_kind),
    .sym_nib(sym_nib), .low_lat(low_lat), .rx_dv(rx_dv), .rx_er(rx_er),
    .rxd(rxd), .line_act(line_act)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // scoreboard queues: packed {dv, er, rxd, act} and the requirement tag
  logic [6:0] exp_q[$];
  string      tag_q[$];
  logic [6:0] last_exp;
  bit         have_last = 0;

  // reference state built from the requirements
  logic [3:0] hk[3];
  logic [3:0] hn[3];
  int  m_st = 0;
  bit  m_dv = 0, m_er = 0, m_act = 0;
  logic [3:0] m_rxd = '0;
  int  m_cnt = 0;
  int  tx_idx = 0, ssd_idx = -100, esd_idx = -100;
  int  sidx = 0;
  bit  prev_dv = 0;

  task automatic check(input logic [6:0] act_v, input logic [6:0] exp_v, input string tag);
    n_chk++;
    if (act_v !== exp_v) begin
      n_err++;
      $display("FAIL %s: {dv,er,rxd,act} actual=%b expected=%b", tag, act_v, exp_v);
    end
  endtask

  task automatic check_int(input int a, input int e, input string tag);
    n_chk++;
    if (a != e) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic send(input logic [3:0] k, input logic [3:0] n, input string tag);
    logic [3:0] dk, dn;
    bit disc;
    disc = low_lat && (k != 4'd0) && (!m_act || m_cnt < 3);
    if (k == 4'd0) begin m_act = 0; m_cnt = 0; end
    else begin
      if (!m_act) m_cnt = 1; else if (m_cnt < 3) m_cnt++;
      m_act = 1;
    end
    if (low_lat) begin dk = k; dn = n; end
    else begin dk = hk[2]; dn = hn[2]; end
    hk[2] = hk[1]; hn[2] = hn[1];
    hk[1] = hk[0]; hn[1] = hn[0];
    hk[0] = k;     hn[0] = n;
    if (disc) dk = 4'd0;
    m_er = 0; m_rxd = '0;
    case (m_st)
      0: if (dk == 4'd2) begin m_dv = 1; m_rxd = 4'h5; m_st = 1; end else m_dv = 0;
      1: if (dk == 4'd3) m_rxd = dn;
         else if (dk == 4'd4) begin m_dv = 0; m_st = 2; end
         else if (dk == 4'd0) begin m_dv = 0; m_er = 1; m_st = 0; end
         else m_er = 1;
      default: begin m_dv = 0; m_st = 0; if (dk != 4'd5) m_er = 1; end
    endcase
    tx_idx++;
    if (k == 4'd2) ssd_idx = tx_idx;
    if (k == 4'd4) esd_idx = tx_idx;
    exp_q.push_back({m_dv, m_er, m_rxd, m_act});
    tag_q.push_back(tag);
    sym_kind = k; sym_nib = n; sym_vld = 1'b1;
    @(negedge clk);
    sym_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) send(4'd0, 4'd0, tag);
  endtask

  // monitor: compare after every strobe edge
  always @(posedge clk) begin
    if (rst_n && sym_vld) begin
      #1;
      sidx++;
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R11: output strobe with empty scoreboard actual=1 expected=0");
      end else begin
        last_exp = exp_q.pop_front();
        have_last = 1;
        check({rx_dv, rx_er, rxd, line_act}, last_exp, tag_q.pop_front());
      end
      if (rx_dv && !prev_dv)
        check_int(sidx - ssd_idx, low_lat ? 0 : 3, low_lat ? "R9 rise latency" : "R3 rise latency");
      if (!rx_dv && prev_dv && !rx_er)
        check_int(sidx - esd_idx, low_lat ? 0 : 3, "R5 fall latency");
      prev_dv = rx_dv;
    end else if (rst_n && have_last) begin
      #1;
      check({rx_dv, rx_er, rxd, line_act}, last_exp, "R11 hold");
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin hk[i] = '0; hn[i] = '0; end
    rst_n = 1'b0; sym_vld = 1'b0; sym_kind = '0; sym_nib = '0; low_lat = 1'b0;
    repeat (3) @(negedge clk);
    check({rx_dv, rx_er, rxd, line_act}, 7'b0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // idle line with beacons
    idle(4, "R12");
    send(4'd7, 4'd0, "R12"); send(4'd7, 4'd0, "R12");
    idle(4, "R12");

    // good frame, default mode
    for (int i = 0; i < 5; i++) send(4'd1, 4'd0, "R2");
    send(4'd2, 4'd0, "R3");
    send(4'd3, 4'hA, "R4"); send(4'd3, 4'h3, "R4");
    send(4'd3, 4'hF, "R4"); send(4'd3, 4'h0, "R4");
    send(4'd4, 4'd0, "R5");
    send(4'd5, 4'd0, "R6");
    idle(4, "R5");

    // bad terminator
    for (int i = 0; i < 3; i++) send(4'd1, 4'd0, "R2");
    send(4'd2, 4'd0, "R3");
    send(4'd3, 4'h6, "R4"); send(4'd3, 4'h9, "R4");
    send(4'd4, 4'd0, "R5");
    send(4'd6, 4'd0, "R7");
    idle(4, "R7");

    // stray codes inside a frame, then truncation by silence
    for (int i = 0; i < 3; i++) send(4'd1, 4'd0, "R2");
    send(4'd2, 4'd0, "R3");
    send(4'd3, 4'h1, "R4");
    send(4'd12, 4'h7, "R8");
    send(4'd7, 4'h2, "R8");
    send(4'd3, 4'h2, "R8");
    idle(4, "R8");

    // terminator followed by an invalid code
    for (int i = 0; i < 3; i++) send(4'd1, 4'd0, "R2");
    send(4'd2, 4'd0, "R3");
    send(4'd3, 4'hC, "R4");
    send(4'd4, 4'd0, "R5");
    send(4'd9, 4'd0, "R7");
    idle(4, "R7");

    // low-latency mode
    low_lat = 1'b1;
    idle(2, "R9");
    send(4'd1, 4'd0, "R10"); send(4'd2, 4'd0, "R10"); send(4'd1, 4'd0, "R10");
    send(4'd1, 4'd0, "R10");
    send(4'd2, 4'd0, "R9");
    send(4'd3, 4'h4, "R9"); send(4'd3, 4'hB, "R9");
    send(4'd4, 4'd0, "R5");
    send(4'd5, 4'd0, "R6");
    idle(3, "R9");

    for (int i = 0; i < 4; i++) send(4'd1, 4'd0, "R10");
    send(4'd2, 4'd0, "R9");
    send(4'd3, 4'hE, "R9");
    send(4'd4, 4'd0, "R5");
    send(4'd6, 4'd0, "R7");
    idle(3, "R7");

    low_lat = 1'b0;
    idle(4, "R12");
    repeat (2) @(negedge clk);
    check_int(exp_q.size(), 0, "R11 scoreboard drained");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule